// File: doc/BRIEF.md
# Peripheral Bus Command and Standby Sequencer

This block is the processor-side engine that places commands on the shared peripheral bus for three instructions: entering standby, polling for service requests, and resetting every device on the chain. An instruction arrives as a one-cycle start pulse with a 2-bit operation select. The block then steps through a fixed cycle schedule. It presents each command nibble one cycle ahead of the active-low strobe and holds the nibble through the strobe's falling edge. It ends every instruction with a one-cycle done pulse that carries the instruction's cycle count.

The standby instruction sends a no-operation command to flush pending device operations, then sends the standby command. After that the block drops the clock-run enable, which stops the system clock while storage keeps its contents. If the 3-nibble output register is all zero when the instruction completes, a force-PC-to-zero pulse is also raised, and the processor halts. The block wakes on a rising edge of any input-register line, or on the card-detect pin (active low) being pulled low and then released while standby is in effect. The clock-run enable returns only after a parameter-set oscillator settle time.

The poll instruction samples the bus nibble during its strobe-low cycle and keeps it as the poll result. It sets the service-request flag when that nibble is non-zero. All pins are plain control and status signals: the bus nibble is sampled in one fixed cycle and the poll result is a held register. No pin carries a valid/ready stream, so nothing exerts back-pressure.

Top module: `hbus_cmd_standby`

## Requirements
- R1: After reset the strobe is high, the command nibble is 0x0, clock-run is 1, and the poll nibble, service-request flag, done and PC-zero outputs are all 0.
- R2: Every command nibble is driven for one cycle with the strobe high. It is then held unchanged for exactly one cycle with the strobe low. Outside a command the nibble is the no-operation code 0x0 and the strobe is high.
- R3: op_sel 0 (standby) drives 0x0 in cycles 1-2 and 0xD in cycles 3-4 after the start is sampled. Done rises in cycle 6 with a count of 6. From cycle 7 clock-run is 0, the strobe is parked low and the nibble is 0x0.
- R4: The PC-zero output pulses together with the standby instruction's done exactly when the output register equals 0x000.
- R5: op_sel 1 (poll) drives 0x5 in cycles 1-2 and captures bus_din at the end of cycle 2. From cycle 3 the poll nibble shows the captured value and the service-request flag equals (value != 0). Done rises in cycle 7 with a count of 7.
- R6: op_sel 2 (bus reset) drives 0xA in cycles 1-2. Done rises in cycle 6 with a count of 6.
- R7: In standby, a 0-to-1 transition on any input-register line wakes the block. A line that is already high when standby begins does not wake it.
- R8: In standby, the card-detect pin seen low and then high wakes the block. If the pin stays high, it does not.
- R9: On a wake, the strobe returns high at once. Clock-run stays 0 for SETTLE_CYC cycles, then returns to 1.
- R10: A start is ignored while an instruction is running, in standby and during settling. A start with op_sel 3 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle instruction start |
| op_sel | input | 2 | 0 standby, 1 poll, 2 bus reset, 3 none |
| outreg | input | OUT_W | Output register value |
| in_lines | input | N_IN | Input-register lines |
| ncd_n | input | 1 | Card-detect pin, active low |
| bus_din | input | 4 | Bus data nibble |
| cmd_str_n | output | 1 | Command strobe, active low |
| cmd_nib | output | 4 | Command nibble |
| clk_run | output | 1 | Clock/oscillator run enable |
| pc_zero | output | 1 | Force program counter to zero |
| poll_nib | output | 4 | Last captured poll nibble |
| sr_flag | output | 1 | Service-request status |
| done | output | 1 | Instruction-complete pulse |
| done_cycles | output | 4 | Cycle count, valid with done |

## Verification
Three kinds of error are targeted directly.
- Capture timing: the bench changes bus_din right after the strobe-low cycle, so a design that latches one cycle late reports the wrong poll nibble.
- Wake qualification: a line held high across standby entry, a falling line, and an idle card-detect pin must leave the block asleep. A level-sensitive or unqualified wake would restart the clock early. The settle boundary is checked on both sides, so an off-by-one counter is caught.
- Restart protection: starts issued mid-instruction, in standby, during settling and with op_sel 3 are each checked. A design that restarted on any of them would lose its done pulse or emit stray commands.

Random instruction mixes with biased zero output registers and zero poll nibbles cover the PC-zero and flag decisions.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    OP_SHUT = 2'd0,
    OP_POLL = 2'd1,
    OP_RST  = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SB_AWAKE  = 2'd0,
    SB_SLEEP  = 2'd1,
    SB_SETTLE = 2'd2
  } sb_e;

  localparam logic [3:0] CMD_NOP   = 4'h0;
  localparam logic [3:0] CMD_POLL  = 4'h5;
  localparam logic [3:0] CMD_SHUT  = 4'hD;
  localparam logic [3:0] CMD_RESET = 4'hA;

  localparam int LEN_SHUT = 6;
  localparam int LEN_POLL = 7;
  localparam int LEN_RST  = 6;
  localparam int STEP_W   = $clog2(LEN_POLL + 1);

  function automatic logic [STEP_W-1:0] op_len(op_e op);
    case (op)
      OP_SHUT: op_len = STEP_W'(LEN_SHUT);
      OP_POLL: op_len = STEP_W'(LEN_POLL);
      OP_RST:  op_len = STEP_W'(LEN_RST);
      default: op_len = '0;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] op_cmd_steps(op_e op);
    case (op)
      OP_SHUT: op_cmd_steps = STEP_W'(4);
      OP_POLL, OP_RST: op_cmd_steps = STEP_W'(2);
      default: op_cmd_steps = '0;
    endcase
  endfunction

  function automatic logic [3:0] op_cmd(op_e op, logic second);
    case (op)
      OP_SHUT: op_cmd = second ? CMD_SHUT : CMD_NOP;
      OP_POLL: op_cmd = CMD_POLL;
      OP_RST:  op_cmd = CMD_RESET;
      default: op_cmd = CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/hbus_cmd_seq.sv
module hbus_cmd_seq
  import hbus_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       sel,
  input  logic             accept_ok,
  input  logic [OUT_W-1:0] outreg,
  output logic             str_n,
  output logic [3:0]       nib,
  output logic             done,
  output logic [3:0]       done_cycles,
  output logic             pc_zero,
  output logic             enter_stby,
  output logic             latch_en
);
  logic [STEP_W-1:0] step_q;
  op_e               op_q;
  logic              busy, in_cmd;
  logic [STEP_W-1:0] len;

  assign busy   = (step_q != '0);
  assign len    = op_len(op_q);
  assign in_cmd = busy && (step_q <= op_cmd_steps(op_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      op_q   <= OP_NONE;
    end else if (!busy) begin
      if (start && accept_ok && (op_e'(sel) != OP_NONE)) begin
        step_q <= STEP_W'(1);
        op_q   <= op_e'(sel);
      end
    end else if (step_q == len) begin
      step_q <= '0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  always_comb begin
    nib         = in_cmd ? op_cmd(op_q, step_q > STEP_W'(2)) : CMD_NOP;
    str_n       = !(in_cmd && !step_q[0]);
    done        = busy && (step_q == len);
    done_cycles = done ? 4'(len) : 4'd0;
    enter_stby  = done && (op_q == OP_SHUT);
    pc_zero     = enter_stby && (outreg == '0);
    latch_en    = !str_n && (op_q == OP_POLL);
  end
endmodule

// File: rtl/hbus_standby.sv
module hbus_standby
  import hbus_pkg::*;
#(
  parameter int N_IN       = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic [N_IN-1:0] in_lines,
  input  logic            ncd_n,
  output logic            clk_run,
  output logic            asleep
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  sb_e             st_q;
  logic [N_IN-1:0] prev_q;
  logic            ncd_seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic            line_rise, ncd_wake;

  assign line_rise = |(in_lines & ~prev_q);
  assign ncd_wake  = ncd_seen_q && ncd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SB_AWAKE;
      prev_q     <= '0;
      ncd_seen_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      prev_q <= in_lines;
      case (st_q)
        SB_AWAKE: begin
          ncd_seen_q <= 1'b0;
          if (enter) st_q <= SB_SLEEP;
        end
        SB_SLEEP: begin
          if (line_rise || ncd_wake) begin
            st_q       <= SB_SETTLE;
            cnt_q      <= '0;
            ncd_seen_q <= 1'b0;
          end else if (!ncd_n) begin
            ncd_seen_q <= 1'b1;
          end
        end
        SB_SETTLE: begin
          if (cnt_q == CNT_W'(SETTLE_CYC - 1)) st_q <= SB_AWAKE;
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= SB_AWAKE;
      endcase
    end
  end

  assign clk_run = (st_q == SB_AWAKE);
  assign asleep  = (st_q == SB_SLEEP);
endmodule

// File: rtl/hbus_poll_cap.sv
module hbus_poll_cap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_en,
  input  logic [3:0] bus_din,
  output logic [3:0] poll_nib,
  output logic       sr_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_nib <= 4'd0;
      sr_flag  <= 1'b0;
    end else if (latch_en) begin
      poll_nib <= bus_din;
      sr_flag  <= |bus_din;
    end
  end
endmodule

// File: rtl/hbus_cmd_standby.sv
module hbus_cmd_standby
  import hbus_pkg::*;
#(
  parameter int OUT_W      = 12,
  parameter int N_IN       = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [1:0]       op_sel,
  input  logic [OUT_W-1:0] outreg,
  input  logic [N_IN-1:0]  in_lines,
  input  logic             ncd_n,
  input  logic [3:0]       bus_din,
  output logic             cmd_str_n,
  output logic [3:0]       cmd_nib,
  output logic             clk_run,
  output logic             pc_zero,
  output logic [3:0]       poll_nib,
  output logic             sr_flag,
  output logic             done,
  output logic [3:0]       done_cycles
);
  logic seq_str_n, enter_stby, latch_en, asleep;

  hbus_cmd_seq #(.OUT_W(OUT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(op_start), .sel(op_sel),
    .accept_ok(clk_run), .outreg(outreg), .str_n(seq_str_n),
    .nib(cmd_nib), .done(done), .done_cycles(done_cycles),
    .pc_zero(pc_zero), .enter_stby(enter_stby), .latch_en(latch_en)
  );

  hbus_standby #(.N_IN(N_IN), .SETTLE_CYC(SETTLE_CYC)) u_sb (
    .clk(clk), .rst_n(rst_n), .enter(enter_stby), .in_lines(in_lines),
    .ncd_n(ncd_n), .clk_run(clk_run), .asleep(asleep)
  );

  hbus_poll_cap u_poll (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .bus_din(bus_din),
    .poll_nib(poll_nib), .sr_flag(sr_flag)
  );

  // Strobe is parked active while the clock is stopped.
  assign cmd_str_n = asleep ? 1'b0 : seq_str_n;
endmodule

// File: rtl/hbus_cmd_standby_chk.sv
module hbus_cmd_standby_chk
  import hbus_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_str_n,
  input logic [3:0] cmd_nib,
  input logic       clk_run,
  input logic       pc_zero,
  input logic [3:0] poll_nib,
  input logic       done,
  input logic [3:0] done_cycles
);
  p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_str_n) && clk_run) |-> $stable(cmd_nib));

  p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_str_n && clk_run) |=> cmd_str_n);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run) |-> ($past(done) && $past(done_cycles) == 4'd6 && !cmd_str_n));

  p_pc_zero_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_zero |-> (done && done_cycles == 4'd6));

  p_poll_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(poll_nib) |-> ($past(!cmd_str_n) && $past(cmd_nib) == CMD_POLL));

  p_asleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> (!done && cmd_nib == CMD_NOP));
endmodule

bind hbus_cmd_standby hbus_cmd_standby_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_str_n(cmd_str_n), .cmd_nib(cmd_nib),
  .clk_run(clk_run), .pc_zero(pc_zero), .poll_nib(poll_nib),
  .done(done), .done_cycles(done_cycles)
);

// File: tb/sim_hbus_cmd_standby.sv
`timescale 1ns/1ps
module sim_hbus_cmd_standby;
  localparam int S = 8;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, op_start = 1'b0, ncd_n = 1'b1;
  logic [1:0] op_sel = 2'd3;
  logic [11:0] outreg = '0;
  logic [N-1:0] in_lines = '0;
  logic [3:0] bus_din = '0;
  logic cmd_str_n, clk_run, pc_zero, sr_flag, done;
  logic [3:0] cmd_nib, poll_nib, done_cycles;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hbus_cmd_standby #(.OUT_W(12), .N_IN(N), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_sel(op_sel),
    .outreg(outreg), .in_lines(in_lines), .ncd_n(ncd_n), .bus_din(bus_din),
    .cmd_str_n(cmd_str_n), .cmd_nib(cmd_nib), .clk_run(clk_run),
    .pc_zero(pc_zero), .poll_nib(poll_nib), .sr_flag(sr_flag),
    .done(done), .done_cycles(done_cycles)
  );

  function automatic int f_len(int op);
    return (op == 1) ? 7 : 6;
  endfunction

  function automatic int f_nib(int op, int k);
    if (op == 0) return (k <= 2) ? 0 : (k <= 4) ? 13 : 0;
    if (k > 2) return 0;
    return (op == 1) ? 5 : 10;
  endfunction

  function automatic int f_str(int op, int k);
    int last = (op == 0) ? 4 : 2;
    return (k <= last && (k % 2) == 0) ? 0 : 1;
  endfunction

  function automatic string f_tag(int op);
    return (op == 0) ? "R3" : (op == 1) ? "R5" : "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input int op, input logic [11:0] orv, input logic [3:0] bn, input bit noise);
    int len = f_len(op);
    @(negedge clk);
    op_start = 1; op_sel = 2'(op); outreg = orv; bus_din = bn;
    @(negedge clk);
    op_start = 0;
    for (int k = 1; k <= len; k++) begin
      chk(cmd_nib == 4'(f_nib(op, k)), {f_tag(op), "/R2 nibble"}, cmd_nib, f_nib(op, k));
      chk(cmd_str_n == 1'(f_str(op, k)), "R2 strobe", cmd_str_n, f_str(op, k));
      chk(done == (k == len), {f_tag(op), " done"}, done, k == len);
      if (k == len) begin
        chk(done_cycles == 4'(len), {f_tag(op), " count"}, done_cycles, len);
        chk(pc_zero == (op == 0 && orv == 0), "R4 pc_zero", pc_zero, op == 0 && orv == 0);
      end
      if (k == 3) bus_din = ~bn;
      if (noise && k >= 2 && k < len) begin
        op_start = 1; op_sel = 2'($urandom % 4);
      end else op_start = 0;
      @(negedge clk);
    end
    op_start = 0;
    if (op == 1) begin
      chk(poll_nib == bn, "R5 poll nibble", poll_nib, bn);
      chk(sr_flag == (bn != 0), "R5 sr flag", sr_flag, bn != 0);
    end
    chk(clk_run == (op != 0), "R3 clk_run after op", clk_run, op != 0);
    if (op == 0) chk(cmd_str_n == 0, "R3 parked strobe", cmd_str_n, 0);
    else chk(!done && cmd_nib == 0, "R10 no restart", cmd_nib, 0);
  endtask

  task automatic settle_check(input bit noise);
    chk(clk_run == 0 && cmd_str_n == 1, "R9 settle start", {clk_run, cmd_str_n}, 1);
    for (int j = 1; j < S; j++) begin
      op_start = noise && (j < S - 1);
      op_sel = 2'($urandom % 3);
      @(negedge clk);
      chk(clk_run == 0, "R9 still settling", clk_run, 0);
    end
    op_start = 0;
    @(negedge clk);
    chk(clk_run == 1, "R9 clock back", clk_run, 1);
    chk(!done && cmd_nib == 0 && cmd_str_n, "R10 start ignored in settle", cmd_nib, 0);
  endtask

  task automatic wake(input int kind, input bit noise);
    if (kind == 0) begin
      in_lines = N'(1) << ($urandom % N);
      @(negedge clk);
      settle_check(noise);
      in_lines = '0;
    end else begin
      ncd_n = 0;
      @(negedge clk);
      chk(clk_run == 0 && cmd_str_n == 0, "R8 low alone no wake", clk_run, 0);
      ncd_n = 1;
      @(negedge clk);
      settle_check(noise);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_str_n == 1 && cmd_nib == 0, "R1 bus idle", cmd_nib, 0);
    chk(clk_run == 1, "R1 clk_run", clk_run, 1);
    chk(poll_nib == 0 && !sr_flag && !done && !pc_zero, "R1 status", poll_nib, 0);

    op_start = 1; op_sel = 2'd3;
    @(negedge clk);
    op_start = 0;
    repeat (3) begin
      chk(cmd_str_n && cmd_nib == 0 && !done, "R10 opcode 3 ignored", cmd_nib, 0);
      @(negedge clk);
    end

    run_op(1, 12'h123, 4'h0, 0);
    run_op(1, 12'h123, 4'hF, 1);
    run_op(2, 12'h000, 4'h3, 1);

    in_lines = 8'h01;
    run_op(0, 12'h000, 4'h0, 1);
    op_start = 1; op_sel = 2'd2;
    @(negedge clk);
    op_start = 0;
    repeat (4) begin
      chk(clk_run == 0 && cmd_nib == 0 && !done, "R7/R10 held line, start in standby", clk_run, 0);
      @(negedge clk);
    end
    in_lines = '0;
    repeat (3) @(negedge clk);
    chk(clk_run == 0, "R7 falling line no wake", clk_run, 0);
    chk(clk_run == 0 && ncd_n, "R8 ncd high no wake", clk_run, 0);
    wake(0, 1);

    run_op(0, 12'h800, 4'h0, 0);
    wake(1, 0);

    for (int i = 0; i < 40; i++) begin
      int op = $urandom % 3;
      logic [11:0] orv = ($urandom % 3 == 0) ? 12'h000 : 12'($urandom);
      logic [3:0] bn = ($urandom % 3 == 0) ? 4'h0 : 4'($urandom);
      run_op(op, orv, bn, 1'($urandom));
      if (op == 0) begin
        repeat ($urandom % 4) @(negedge clk);
        wake($urandom % 2, 1'($urandom));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule